// File: doc/BRIEF.md
# Auto Acknowledge Transmit Controller

This block sequences the transmitter of a power-delivery style link. A transmission can begin in three ways. Software can pulse a start bit. A received message that passed its CRC check can start an acknowledge that the block builds itself. In the delayed mode, a good-CRC reception can instead arm a tick timer that starts the transmitter when it expires. Each transmission sends the preamble first and the payload afterwards. The line encoder reports the end of each phase, and the block answers with single-cycle start pulses and a final done pulse.

The acknowledge header is a 16-bit word. It carries the configured role and revision bits and the message ID of the received message. The header is loaded when the acknowledge is triggered and is held stable until the next acknowledge. `hdr_sel` tells the payload path whether to send this header or the contents of the transmit FIFO. Start and flush are self-clearing request pulses. The flush request produces a one-cycle flush command for the transmit FIFO. All control pins are plain levels or pulses. No stream handshake exists, because the encoder paces both phases itself through `pre_end` and `pay_end`.

Top module: `ack_tx_ctrl`

## Requirements
- R1: After reset the block is idle and `pre_start`, `pay_start`, `done`, `fifo_flush` and `hdr_sel` are all low.
- R2: A `start_req` pulse while idle raises `pre_start` for one cycle, one cycle later, with `hdr_sel` low.
- R3: While the preamble is in progress, `pre_end` raises `pay_start` one cycle later. `pay_start` never occurs without a preamble before it. At most one of `pre_start`, `pay_start` and `done` is high in any cycle.
- R4: While the payload is in progress, `pay_end` raises `done` one cycle later, and the block returns to idle.
- R5: With `auto_ack_en` high, a `crc_good` pulse while idle raises `pre_start` one cycle later with `hdr_sel` high.
- R6: The header has these fields:
  - bits [4:0] = 00001 (message type)
  - bit 5 = `data_role`
  - bits [7:6] = `spec_rev` (00 = revision 1.0, 01 = revision 2.0)
  - bit 8 = `power_role` (1 = source) when `rx_sop_primary` is high, and 0 otherwise
  - bits [11:9] = `rx_msg_id`
  - bits [15:12] = 0 (no data objects)
- R7: With `auto_ack_en` low and `delay_en` high, a `crc_good` pulse while idle arms the timer. `pre_start` (with `hdr_sel` low) follows one cycle after the DLY_TICKS-th `tick` counted after arming.
- R8: During the delay wait, `start_req` cancels the wait and raises `pre_start` one cycle later. A `flush_req` during the wait cancels it, and no later tick starts the transmitter.
- R9: A `flush_req` while idle or waiting raises `fifo_flush` one cycle later. A `flush_req` during the preamble or the payload has no effect.
- R10: When `start_req` and an auto-acknowledge `crc_good` arrive in the same idle cycle, `start_req` wins and `hdr_sel` is low. While a transmission is in progress, `start_req` and `crc_good` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| auto_ack_en | input | 1 | Enable automatic acknowledge on good CRC |
| delay_en | input | 1 | Enable delayed transmit start on good CRC |
| power_role | input | 1 | Power role for the header, 1 = source |
| data_role | input | 1 | Data role for the header, 1 = source side |
| spec_rev | input | 2 | Spec revision code for the header |
| start_req | input | 1 | Self-clearing start request pulse |
| flush_req | input | 1 | Self-clearing FIFO flush request pulse |
| crc_good | input | 1 | Pulse: received message passed CRC |
| rx_msg_id | input | 3 | Message ID of the received message |
| rx_sop_primary | input | 1 | Received message was of the primary packet type |
| tick | input | 1 | Delay timer tick |
| pre_end | input | 1 | Encoder: preamble finished |
| pay_end | input | 1 | Encoder: payload finished |
| hdr | output | 16 | Acknowledge header word |
| hdr_sel | output | 1 | Payload source is the header (1) or the FIFO (0) |
| pre_start | output | 1 | Preamble start pulse |
| pay_start | output | 1 | Payload start pulse |
| done | output | 1 | Transmission done pulse |
| fifo_flush | output | 1 | Transmit FIFO flush pulse |

## Verification
Every output pulse is registered, so it is due in exactly the cycle after the edge that samples its cause. For the delayed start, the cause is the DLY_TICKS-th tick after arming. When the bench drives a stimulus, it records the cycle number and pushes the pulse kind, the cycle and, for acknowledges, the header into a scoreboard queue with a due cycle one greater than the recorded cycle. A monitor samples at the falling edge. It pops one entry per observed pulse and compares the kind, the cycle and the header. Any pulse with no entry waiting, including one that should have been ignored, counts as a failure, and so does any entry left unmatched at the end.

// File: rtl/ack_tx_pkg.sv
package ack_tx_pkg;
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_PRE, S_PAY} tx_state_e;
  localparam int unsigned HDR_W   = 16;
  localparam int unsigned MSGID_W = 3;
  localparam logic [4:0]  ACK_MSG_TYPE = 5'b00001;
endpackage

// File: rtl/ack_hdr_build.sv
module ack_hdr_build
  import ack_tx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               power_role,
  input  logic               data_role,
  input  logic [1:0]         spec_rev,
  input  logic               sop_primary,
  input  logic [MSGID_W-1:0] msg_id,
  output logic [HDR_W-1:0]   hdr
);
  localparam int unsigned NDO_W = HDR_W - 9 - MSGID_W;

  logic [HDR_W-1:0] hdr_d;

  always_comb begin
    hdr_d = {{NDO_W{1'b0}}, msg_id, (power_role & sop_primary),
             spec_rev, data_role, ACK_MSG_TYPE};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hdr <= '0;
    else if (load) hdr <= hdr_d;
  end
endmodule

// File: rtl/ack_delay_timer.sv
module ack_delay_timer #(
  parameter int unsigned DLY_TICKS = 170
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic expire
);
  localparam int unsigned CNT_W = (DLY_TICKS > 1) ? $clog2(DLY_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DLY_TICKS - 1);

  logic [CNT_W-1:0] cnt;

  assign expire = run && tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (expire)   cnt <= '0;
    else if (tick)     cnt <= cnt + 1'b1;
  end

  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !expire) |=> (cnt == $past(cnt) + 1'b1))
    else $error("R7 timer did not advance on tick");
endmodule

// File: rtl/ack_tx_fsm.sv
module ack_tx_fsm
  import ack_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_req,
  input  logic      flush_req,
  input  logic      crc_good,
  input  logic      auto_ack_en,
  input  logic      delay_en,
  input  logic      pre_end,
  input  logic      pay_end,
  input  logic      tmr_expire,
  output tx_state_e state,
  output logic      hdr_load,
  output logic      hdr_sel,
  output logic      pre_start,
  output logic      pay_start,
  output logic      done,
  output logic      fifo_flush
);
  tx_state_e nxt;
  logic go_pre, go_ack, pay_n, done_n, flush_n;

  always_comb begin
    nxt = state; go_pre = 1'b0; go_ack = 1'b0;
    pay_n = 1'b0; done_n = 1'b0; flush_n = 1'b0;
    unique case (state)
      S_IDLE: begin
        flush_n = flush_req;
        if (start_req) begin
          go_pre = 1'b1; nxt = S_PRE;
        end else if (crc_good && auto_ack_en) begin
          go_pre = 1'b1; go_ack = 1'b1; nxt = S_PRE;
        end else if (crc_good && delay_en) begin
          nxt = S_WAIT;
        end
      end
      S_WAIT: begin
        flush_n = flush_req;
        if (start_req || (tmr_expire && !flush_req)) begin
          go_pre = 1'b1; nxt = S_PRE;
        end else if (flush_req) begin
          nxt = S_IDLE;
        end
      end
      S_PRE: if (pre_end) begin pay_n = 1'b1; nxt = S_PAY; end
      S_PAY: if (pay_end) begin done_n = 1'b1; nxt = S_IDLE; end
      default: nxt = S_IDLE;
    endcase
  end

  assign hdr_load = go_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; hdr_sel <= 1'b0; pre_start <= 1'b0;
      pay_start <= 1'b0; done <= 1'b0; fifo_flush <= 1'b0;
    end else begin
      state      <= nxt;
      pre_start  <= go_pre;
      pay_start  <= pay_n;
      done       <= done_n;
      fifo_flush <= flush_n;
      if (go_pre) hdr_sel <= go_ack;
    end
  end

  p_pulse_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pre_start, pay_start, done}))
    else $error("R3 overlapping phase pulses");

  p_pay_after_pre_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pay_start |-> ($past(state) == S_PRE))
    else $error("R3 payload without preamble");

  p_ack_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && crc_good && auto_ack_en && !start_req) |=> (pre_start && hdr_sel))
    else $error("R5 acknowledge not started");

  p_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PAY && pay_end) |=> (done && state == S_IDLE))
    else $error("R4 done missing");

  p_flush_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PRE || state == S_PAY) |=> !fifo_flush)
    else $error("R9 flush while busy");

  p_start_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && start_req) |=> (pre_start && !hdr_sel))
    else $error("R10 start priority");
endmodule

// File: rtl/ack_tx_ctrl.sv
module ack_tx_ctrl
  import ack_tx_pkg::*;
#(
  parameter int unsigned DLY_TICKS = 170
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         auto_ack_en,
  input  logic         delay_en,
  input  logic         power_role,
  input  logic         data_role,
  input  logic [1:0]   spec_rev,
  input  logic         start_req,
  input  logic         flush_req,
  input  logic         crc_good,
  input  logic [2:0]   rx_msg_id,
  input  logic         rx_sop_primary,
  input  logic         tick,
  input  logic         pre_end,
  input  logic         pay_end,
  output logic [15:0]  hdr,
  output logic         hdr_sel,
  output logic         pre_start,
  output logic         pay_start,
  output logic         done,
  output logic         fifo_flush
);
  tx_state_e state;
  logic hdr_load, tmr_expire, tmr_run;

  assign tmr_run = (state == S_WAIT);

  ack_tx_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .flush_req(flush_req),
    .crc_good(crc_good), .auto_ack_en(auto_ack_en), .delay_en(delay_en),
    .pre_end(pre_end), .pay_end(pay_end), .tmr_expire(tmr_expire),
    .state(state), .hdr_load(hdr_load), .hdr_sel(hdr_sel),
    .pre_start(pre_start), .pay_start(pay_start), .done(done),
    .fifo_flush(fifo_flush)
  );

  ack_delay_timer #(.DLY_TICKS(DLY_TICKS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(tmr_run), .tick(tick), .expire(tmr_expire)
  );

  ack_hdr_build u_hdr (
    .clk(clk), .rst_n(rst_n), .load(hdr_load), .power_role(power_role),
    .data_role(data_role), .spec_rev(spec_rev), .sop_primary(rx_sop_primary),
    .msg_id(rx_msg_id), .hdr(hdr)
  );

  p_hdr_fields_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_load |=> (hdr[4:0] == ACK_MSG_TYPE && hdr[11:9] == $past(rx_msg_id)
                  && hdr[15:12] == 4'd0))
    else $error("R6 header fields");
endmodule

// File: tb/tb_ack_tx_ctrl.sv
module tb_ack_tx_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DLY = 4;
  localparam int K_PRE = 0, K_PAY = 1, K_DONE = 2, K_FLUSH = 3;

  logic clk = 0, rst_n = 0;
  logic auto_ack_en = 0, delay_en = 0, power_role = 0, data_role = 0;
  logic [1:0] spec_rev = 0;
  logic start_req = 0, flush_req = 0, crc_good = 0, rx_sop_primary = 0;
  logic [2:0] rx_msg_id = 0;
  logic tick = 0, pre_end = 0, pay_end = 0;
  logic [15:0] hdr;
  logic hdr_sel, pre_start, pay_start, done, fifo_flush;

  always #(CLK_PERIOD/2) clk = ~clk;

  ack_tx_ctrl #(.DLY_TICKS(DLY)) dut (
    .clk(clk), .rst_n(rst_n), .auto_ack_en(auto_ack_en), .delay_en(delay_en),
    .power_role(power_role), .data_role(data_role), .spec_rev(spec_rev),
    .start_req(start_req), .flush_req(flush_req), .crc_good(crc_good),
    .rx_msg_id(rx_msg_id), .rx_sop_primary(rx_sop_primary), .tick(tick),
    .pre_end(pre_end), .pay_end(pay_end), .hdr(hdr), .hdr_sel(hdr_sel),
    .pre_start(pre_start), .pay_start(pay_start), .done(done),
    .fifo_flush(fifo_flush)
  );

  typedef struct {
    int          cyc;
    int          kind;
    logic        sel;
    logic [15:0] h;
    string       req;
  } ev_t;

  ev_t q[$];
  int cyc = 0, n_chk = 0, n_fail = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] exp_hdr(logic pr, logic dr, logic [1:0] rv,
                                          logic sop, logic [2:0] id);
    return {4'b0000, id, pr & sop, rv, dr, 5'b00001};
  endfunction

  task automatic push(int kind, logic sel, logic [15:0] h, string req);
    ev_t e;
    e.cyc = cyc + 1; e.kind = kind; e.sel = sel; e.h = h; e.req = req;
    q.push_back(e);
  endtask

  task automatic see(int kind);
    ev_t e;
    n_chk++;
    if (q.size() == 0) begin
      n_fail++;
      $display("FAIL R10/R9 unexpected pulse kind %0d at cycle %0d, expected none", kind, cyc);
    end else begin
      e = q.pop_front();
      if (e.kind != kind || e.cyc != cyc ||
          (kind == K_PRE && (hdr_sel !== e.sel || (e.sel && hdr !== e.h)))) begin
        n_fail++;
        $display("FAIL %s: got kind %0d cyc %0d sel %0b hdr %h, expected kind %0d cyc %0d sel %0b hdr %h",
                 e.req, kind, cyc, hdr_sel, hdr, e.kind, e.cyc, e.sel, e.h);
      end
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (pre_start)  see(K_PRE);
    if (pay_start)  see(K_PAY);
    if (done)       see(K_DONE);
    if (fifo_flush) see(K_FLUSH);
  end

  // which: 0 start, 1 flush, 2 crc, 3 pre_end, 4 pay_end, 5 tick
  task automatic act(int which, int kind, logic sel, logic [15:0] h, string req);
    @(negedge clk);
    case (which)
      0: start_req = 1; 1: flush_req = 1; 2: crc_good = 1;
      3: pre_end = 1;   4: pay_end = 1;   default: tick = 1;
    endcase
    if (kind >= 0) push(kind, sel, h, req);
    @(negedge clk);
    start_req = 0; flush_req = 0; crc_good = 0; pre_end = 0; pay_end = 0; tick = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_tx(string req);
    idle(2);
    act(3, K_PAY, 0, 0, "R3 payload after preamble");
    idle(1);
    act(4, K_DONE, 0, 0, req);
  endtask

  task automatic summary;
    foreach (q[i]) begin
      n_chk++; n_fail++;
      $display("FAIL %s: missing pulse kind %0d, expected at cycle %0d", q[i].req, q[i].kind, q[i].cyc);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    summary();
  end

  initial begin
    idle(3);
    n_chk++;
    if ({pre_start, pay_start, done, fifo_flush, hdr_sel} !== 5'b0) begin
      n_fail++;
      $display("FAIL R1: outputs %b in reset, expected 00000",
               {pre_start, pay_start, done, fifo_flush, hdr_sel});
    end
    rst_n = 1;
    idle(2);
    n_chk++;
    if ({pre_start, pay_start, done, fifo_flush, hdr_sel} !== 5'b0) begin
      n_fail++;
      $display("FAIL R1: outputs %b after reset, expected 00000",
               {pre_start, pay_start, done, fifo_flush, hdr_sel});
    end

    // R2 software start, R3/R4 phase sequence
    act(0, K_PRE, 0, 0, "R2 start");
    finish_tx("R4 done");
    // R9 flush while idle
    act(1, K_FLUSH, 0, 0, "R9 flush idle");

    // R5/R6 auto acknowledge, primary packet type
    auto_ack_en = 1; power_role = 1; data_role = 1; spec_rev = 2'b01;
    rx_msg_id = 3'd5; rx_sop_primary = 1;
    act(2, K_PRE, 1, exp_hdr(1, 1, 2'b01, 1, 3'd5), "R5 R6 ack sop");
    finish_tx("R4 done ack");
    // R6 non-primary packet: power role bit forced to 0
    data_role = 0; spec_rev = 2'b00; rx_msg_id = 3'd2; rx_sop_primary = 0;
    act(2, K_PRE, 1, exp_hdr(1, 0, 2'b00, 0, 3'd2), "R6 ack non-sop");
    // R9 flush and R10 start/crc ignored while busy
    act(1, -1, 0, 0, "");
    act(0, -1, 0, 0, "");
    act(2, -1, 0, 0, "");
    finish_tx("R4 done ack2");

    // R7 delayed start
    auto_ack_en = 0; delay_en = 1;
    act(2, -1, 0, 0, "");
    act(5, -1, 0, 0, ""); act(5, -1, 0, 0, ""); act(5, -1, 0, 0, "");
    idle(2);
    act(5, K_PRE, 0, 0, "R7 delayed start");
    finish_tx("R4 done delayed");

    // R8 cancel by flush
    act(2, -1, 0, 0, "");
    act(5, -1, 0, 0, ""); act(5, -1, 0, 0, "");
    act(1, K_FLUSH, 0, 0, "R8 R9 flush cancels wait");
    for (int i = 0; i < DLY + 1; i++) act(5, -1, 0, 0, "");
    idle(2);

    // R8 cancel by start
    act(2, -1, 0, 0, "");
    act(5, -1, 0, 0, "");
    act(0, K_PRE, 0, 0, "R8 start during wait");
    for (int i = 0; i < DLY; i++) act(5, -1, 0, 0, "");
    finish_tx("R4 done after cancel");

    // R10 priority: start beats auto ack in the same cycle
    delay_en = 0; auto_ack_en = 1;
    @(negedge clk);
    start_req = 1; crc_good = 1;
    push(K_PRE, 0, 0, "R10 start priority");
    @(negedge clk);
    start_req = 0; crc_good = 0;
    finish_tx("R4 done prio");

    idle(4);
    summary();
  end
endmodule